// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers bytes from an asynchronous serial line. A programmable divisor turns the system clock into a sample tick, and eight ticks make up one bit period. The line is first passed through a two-flop synchronizer. A falling edge on the synchronized line opens a candidate start bit. The candidate counts as a real start bit only if the line stays low long enough. After that, each data bit is decided by a two-out-of-three vote over samples taken in the middle of the bit.

Software sets the 16-bit divisor value, called BRR here, through two byte-wide write strobes that share one data bus. Downstream logic receives the assembled byte, a one-cycle valid pulse and a framing-error flag. The flag describes the frame that was delivered last.

Top module: `uart_os_rx`

## Requirements
- R1: Both divisor bytes are cleared by reset. A write with `div_hi_we` loads `div_wdata` into BRR bits 15..8, and a write with `div_lo_we` loads it into BRR bits 7..0.
- R2: For BRR from 1 to 65535 a sample tick occurs every BRR+1 system clocks. For BRR of 0 it occurs every 2 clocks. One bit period lasts 8 ticks, so the bit time is 8·(BRR+1) clocks, or 16 clocks when BRR is 0.
- R3: The line passes through two flops before it is sampled. A start is taken when a tick samples the line low while the receiver is armed. That tick counts as low sample 1. Samples 2, 3 and 4 must also be low. If any of them is high, the receiver drops back to idle and delivers nothing.
- R4: Each data bit and the stop bit take the majority value of samples 4, 5 and 6 of their bit period. A single sample that disagrees with the other two does not change the result.
- R5: Eight data bits follow the start bit. The first one received is placed in `rx_data[0]` and the last in `rx_data[7]`.
- R6: When the stop bit has been voted, `rx_valid` is high for exactly one clock. `rx_data` changes only in that cycle and holds the byte until the next frame completes.
- R7: A stop bit voted high delivers the byte with `rx_frame_err` = 0. A stop bit voted low delivers the byte with `rx_frame_err` = 1. The flag changes only together with `rx_valid`.
- R8: After a frame completes, and after reset, the receiver is unarmed. It arms again only once a tick samples the line high, so a line that stays low produces no further frames.
- R9: After reset, `rx_data` is 0, and `rx_valid` and `rx_frame_err` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_hi_we | input | 1 | Write strobe for the high divisor byte |
| div_lo_we | input | 1 | Write strobe for the low divisor byte |
| div_wdata | input | 8 | Byte written into the selected divisor half |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |
| rx_frame_err | output | 1 | Stop bit of the last frame was voted low |

## Verification
The bench runs frames at three divisor settings: BRR of 0 (the special case), a small value, and one that uses both bytes. A design with a wrong tick period or a mishandled high byte would deliver garbled bytes in these runs. A low pulse three samples long must be rejected, so a design that confirms the start on fewer samples would report a spurious byte. A one-tick inverted spike placed in the middle of a data bit has to be outvoted, which a single-sample receiver would fail. A low stop bit must deliver the byte with the error flag set. The line is then held low for several bit times, so a design that re-arms without seeing the line high would produce phantom zero bytes.

// File: rtl/rx_pkg.sv
package rx_pkg;

    localparam int OSR       = 8;
    localparam int DATA_BITS = 8;
    localparam int START_LOW = 4;
    localparam int PH_W      = $clog2(OSR);
    localparam int BIDX_W    = $clog2(DATA_BITS);

    // zero-based phase values of the three vote samples (4th, 5th, 6th tick)
    localparam logic [PH_W-1:0] VOTE_A  = PH_W'(OSR/2 - 1);
    localparam logic [PH_W-1:0] VOTE_B  = PH_W'(OSR/2);
    localparam logic [PH_W-1:0] VOTE_C  = PH_W'(OSR/2 + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0] PH_CONF = PH_W'(START_LOW - 1);

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 ferr;
    } rx_result_t;

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hi_we,
    input  logic             lo_we,
    input  logic [7:0]       wdata,
    output logic             tick,
    output logic [DIV_W-1:0] brr
);
    localparam int HALF = DIV_W / 2;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            brr <= '0;
        end else begin
            if (hi_we) brr[DIV_W-1:HALF] <= wdata[HALF-1:0];
            if (lo_we) brr[HALF-1:0]     <= wdata[HALF-1:0];
        end
    end

    // BRR of 0 behaves like BRR of 1: period of two clocks
    assign limit = (brr == '0) ? DIV_W'(1) : brr;
    assign tick  = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rx_engine.sv
module rx_engine
    import rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 line_s,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 ferr_o
);
    rx_state_e            state;
    logic [PH_W-1:0]      ph;
    logic [PH_W-1:0]      ph_n;
    logic [BIDX_W-1:0]    bidx;
    logic [1:0]           votes;
    logic [DATA_BITS-1:0] shreg;
    logic                 armed;
    logic                 voted;
    rx_result_t           res;

    assign ph_n  = ph + 1'b1;
    assign voted = majority3(votes[0], votes[1], line_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            ph      <= '0;
            bidx    <= '0;
            votes   <= '0;
            shreg   <= '0;
            armed   <= 1'b0;
            res     <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        if (line_s) begin
                            armed <= 1'b1;
                        end else if (armed) begin
                            state <= RX_START;
                            ph    <= '0;
                            armed <= 1'b0;
                        end
                    end
                    RX_START: begin
                        ph <= ph_n;
                        if (ph_n <= PH_CONF && line_s) begin
                            state <= RX_IDLE;
                            armed <= 1'b1;
                        end else if (ph_n == PH_LAST) begin
                            state <= RX_DATA;
                            bidx  <= '0;
                        end
                    end
                    RX_DATA: begin
                        ph <= ph_n;
                        if (ph_n == VOTE_A) votes[0] <= line_s;
                        if (ph_n == VOTE_B) votes[1] <= line_s;
                        if (ph_n == VOTE_C) shreg <= {voted, shreg[DATA_BITS-1:1]};
                        if (ph_n == PH_LAST) begin
                            if (bidx == BIDX_W'(DATA_BITS - 1)) state <= RX_STOP;
                            else                                bidx  <= bidx + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        ph <= ph_n;
                        if (ph_n == VOTE_A) votes[0] <= line_s;
                        if (ph_n == VOTE_B) votes[1] <= line_s;
                        if (ph_n == VOTE_C) begin
                            res.data <= shreg;
                            res.ferr <= ~voted;
                            valid_o  <= 1'b1;
                            state    <= RX_IDLE;
                            armed    <= 1'b0;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign data_o = res.data;
    assign ferr_o = res.ferr;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import rx_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       div_hi_we,
    input  logic       div_lo_we,
    input  logic [7:0] div_wdata,
    input  logic       rx_line,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_frame_err
);
    logic             sample_tick;
    logic             line_sync;
    logic [DIV_W-1:0] brr_val;

    rx_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst   (rst),
        .hi_we (div_hi_we),
        .lo_we (div_lo_we),
        .wdata (div_wdata),
        .tick  (sample_tick),
        .brr   (brr_val)
    );

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_sync)
    );

    rx_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .tick    (sample_tick),
        .line_s  (line_sync),
        .data_o  (rx_data),
        .valid_o (rx_valid),
        .ferr_o  (rx_frame_err)
    );
endmodule

// File: rtl/uart_os_rx_checker.sv
module uart_os_rx_checker #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             div_hi_we,
    input logic             div_lo_we,
    input logic [7:0]       div_wdata,
    input logic [DIV_W-1:0] brr,
    input logic [7:0]       rx_data,
    input logic             rx_valid,
    input logic             rx_frame_err
);
    a_r1_hi_byte_load: assert property (@(posedge clk) disable iff (rst)
        div_hi_we |=> brr[DIV_W-1:DIV_W/2] == $past(div_wdata));

    a_r1_lo_byte_load: assert property (@(posedge clk) disable iff (rst)
        div_lo_we |=> brr[DIV_W/2-1:0] == $past(div_wdata));

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_data));

    a_r7_ferr_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_frame_err));
endmodule

bind uart_os_rx uart_os_rx_checker #(.DIV_W(DIV_W)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .tick         (sample_tick),
    .div_hi_we    (div_hi_we),
    .div_lo_we    (div_lo_we),
    .div_wdata    (div_wdata),
    .brr          (brr_val),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err)
);

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       div_hi_we = 1'b0;
    logic       div_lo_we = 1'b0;
    logic [7:0] div_wdata = 8'h00;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;

    int checks = 0;
    int fails  = 0;
    int tick_per = 2;
    logic [7:0] last_byte = 8'h00;
    logic [8:0] exp_q[$];   // {ferr, data}

    always #10 clk = ~clk;

    uart_os_rx u_uart_os_rx (
        .clk(clk), .rst(rst), .div_hi_we(div_hi_we), .div_lo_we(div_lo_we),
        .div_wdata(div_wdata), .rx_line(rx_line), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: R5 R6 R7 scoreboard
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                check("R3/R8 unexpected frame", {7'd0, rx_frame_err, rx_data}, 16'hFFFF);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check("R5 data", {8'd0, rx_data}, {8'd0, e[7:0]});
                check("R7 ferr", {15'd0, rx_frame_err}, {15'd0, e[8]});
            end
        end
    end

    task automatic set_brr(input logic [15:0] v);
        @(negedge clk);
        div_hi_we = 1'b1; div_wdata = v[15:8];
        @(negedge clk);
        div_hi_we = 1'b0; div_lo_we = 1'b1; div_wdata = v[7:0];
        @(negedge clk);
        div_lo_we = 1'b0;
        tick_per = (v == 16'd0) ? 2 : int'(v) + 1;
    endtask

    task automatic hold(input logic lvl, input int nclk);
        @(negedge clk);
        rx_line = lvl;
        repeat (nclk - 1) @(negedge clk);
    endtask

    // glitch_bit: data bit index whose center gets a one-tick inverted spike (-1 none)
    task automatic send(input logic [7:0] b, input logic stop, input int glitch_bit);
        int bt;
        bt = 8 * tick_per;
        exp_q.push_back({~stop, b});
        hold(1'b0, bt);
        for (int i = 0; i < 8; i++) begin
            if (i == glitch_bit) begin
                hold(b[i], bt/2 - tick_per/2);
                hold(~b[i], tick_per);
                hold(b[i], bt - (bt/2 - tick_per/2) - tick_per);
            end else begin
                hold(b[i], bt);
            end
        end
        hold(stop, bt);
        last_byte = b;
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 data", {8'd0, rx_data}, 16'h0000);
        check("R9 valid", {15'd0, rx_valid}, 16'h0000);
        check("R9 ferr", {15'd0, rx_frame_err}, 16'h0000);
        @(negedge clk) rst = 1'b0;
        hold(1'b1, 40);

        // R2 BRR=0 special case (16 clocks per bit)
        send(8'hA5, 1'b1, -1); hold(1'b1, 32);
        send(8'h01, 1'b1, -1); hold(1'b1, 32);
        // R1 R2 small divisor
        set_brr(16'd3); hold(1'b1, 64);
        send(8'h80, 1'b1, -1); hold(1'b1, 64);
        send(8'h3C, 1'b1, -1); hold(1'b1, 64);
        // R6 data held between frames
        check("R6 hold", {8'd0, rx_data}, {8'd0, last_byte});
        // R3 short low pulse: three samples only, must be rejected
        hold(1'b0, 3 * tick_per);
        hold(1'b1, 128);
        check("R3 reject", exp_q.size(), 16'd0);
        check("R3 data kept", {8'd0, rx_data}, {8'd0, last_byte});
        // R4 majority vote outvotes a single bad sample
        send(8'h5A, 1'b1, 3); hold(1'b1, 64);
        send(8'hFF, 1'b1, 0); hold(1'b1, 64);
        // R7 low stop bit, R8 line stays low afterwards
        send(8'hC3, 1'b0, -1);
        hold(1'b0, 3 * 8 * tick_per);
        check("R8 no rearm", exp_q.size(), 16'd0);
        check("R7 ferr held", {15'd0, rx_frame_err}, 16'h0001);
        hold(1'b1, 64);
        send(8'h00, 1'b1, -1); hold(1'b1, 64);
        check("R7 ferr cleared", {15'd0, rx_frame_err}, 16'h0000);
        // R1 both bytes: BRR = 0x0102
        set_brr(16'h0102); hold(1'b1, 8 * tick_per);
        send(8'h96, 1'b1, -1); hold(1'b1, 8 * tick_per);
        send(8'h69, 1'b1, -1); hold(1'b1, 8 * tick_per);
        check("R6 final hold", {8'd0, rx_data}, 16'h0069);
        check("R5 queue drained", exp_q.size(), 16'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule